// File: doc/BRIEF.md
# Per-slave security firewall

This block sits between an interconnect and a group of slave ports and holds one security attribute for each slave. Every request arrives with the index of the slave it targets and a flag that says whether the issuing master is secure. A slave marked secure takes only secure requests. A slave marked nonsecure takes every request. A permitted request goes straight out on the forward port. A refused request never reaches the slave. The block takes it in and answers it locally with a decode-error response one cycle later, on a response port that supports backpressure.

A small configuration port writes the attributes. Only a secure master can write them, and no access can read them back. Each slave has its own state machine with two states. The state is `SLOT_OPEN` when no change is waiting. A write moves the slot to `SLOT_HOLD`, which means a new value is parked. The slot commits the parked value and goes back to `SLOT_OPEN` on the first cycle its outstanding-transaction count is zero, unless another write arrives in that same cycle; in that case the slot stays in `SLOT_HOLD`.

The error responder moves between `ERR_IDLE` and `ERR_HOLD`. It enters `ERR_HOLD` when it captures a refused request and leaves it when the response is taken. The configuration port moves between `CFG_IDLE` and `CFG_RESP` in the same way.

Top module: `slv_sec_firewall`

## Requirements
- R1: After reset every slave is secure, every outstanding count is zero, and `err_valid` and `cfg_rsp_valid` are low.
- R2: A nonsecure request (`req_secure`=0) to a secure slave never raises `fwd_valid`. It is accepted (`req_ready`=1) when the error slot is free, and `err_valid` rises on the next cycle with `err_slv` equal to the request's slave index.
- R3: A secure request to any slave, or any request to a nonsecure slave, is forwarded. `fwd_valid` follows `req_valid`, `fwd_slv` equals `req_slv`, and `req_ready` follows `fwd_ready`. The one exception is the count limit in R7.
- R4: A configuration access is answered one cycle after its handshake. A secure write to slave `cfg_slv` with `cfg_wdata` (1 = secure, 0 = nonsecure) gets response code 2'b00 (OKAY). Any access with `cfg_secure`=0 gets code 2'b11 (DECERR) and changes no setting.
- R5: A configuration read from a secure master returns `cfg_rsp_rdata` of zero with code 2'b00, whatever the settings are, and changes nothing.
- R6: A written setting is copied into the active setting at the first clock edge, after the write edge, at which that slave's outstanding count is zero. Until that edge, requests are checked against the old setting.
- R7: Each accepted forward increments that slave's count, and each `cpl_valid` pulse for `cpl_slv` decrements it. A request to a slave whose count is at its maximum (2^CNT_W-1) is stalled, with `fwd_valid` and `req_ready` both low.
- R8: While `err_valid` is high and `err_ready` is low, `err_valid` and `err_slv` hold their values, and a further refused request is stalled (`req_ready`=0).
- R9: While a configuration response waits with `cfg_rsp_ready` low, `cfg_ready` is low and the response holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken, either forwarded or refused |
| req_slv | input | IDX_W | Target slave index |
| req_secure | input | 1 | 1 when the request comes from a secure master |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Slave side accepts the forward |
| fwd_slv | output | IDX_W | Slave index of the forwarded request |
| cpl_valid | input | 1 | One transaction to `cpl_slv` has completed |
| cpl_slv | input | IDX_W | Slave index of the completion |
| err_valid | output | 1 | Local decode-error response valid |
| err_ready | input | 1 | Error response taken |
| err_slv | output | IDX_W | Slave index of the refused request |
| cfg_valid | input | 1 | Configuration access present |
| cfg_ready | output | 1 | Configuration access taken |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_secure | input | 1 | 1 when the configuring master is secure |
| cfg_slv | input | IDX_W | Slave whose setting is addressed |
| cfg_wdata | input | 1 | New setting, 1 = secure |
| cfg_rsp_valid | output | 1 | Configuration response valid |
| cfg_rsp_ready | input | 1 | Configuration response taken |
| cfg_rsp_resp | output | 2 | 2'b00 OKAY, 2'b11 DECERR |
| cfg_rsp_rdata | output | DATA_W | Read data, always zero |

## Verification
The case that is hardest to reach from the ports is a setting change that is parked while transactions are still in flight. To get there, the stimulus first builds up a count of several outstanding forwards to one slave, then writes that slave's setting, then probes the slave with nonsecure requests while the completions trickle back one at a time. The change must land exactly on the edge after the count reaches zero.

The same count is also driven to its maximum, so the stall is exercised. A long random phase then mixes writes, reads, nonsecure configuration attempts and error backpressure against a behavioural model that is compared on every cycle.

// File: rtl/fw_pkg.sv
package fw_pkg;
    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_DECERR = 2'b11
    } resp_e;

    typedef enum logic {
        SLOT_OPEN = 1'b0,
        SLOT_HOLD = 1'b1
    } slot_st_e;

    typedef enum logic {
        ERR_IDLE = 1'b0,
        ERR_HOLD = 1'b1
    } err_st_e;

    typedef enum logic {
        CFG_IDLE = 1'b0,
        CFG_RESP = 1'b1
    } cfg_st_e;
endpackage

// File: rtl/fw_slot.sv
module fw_slot
    import fw_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic wr,
    input  logic wr_sec,
    output logic sec_q,
    output logic cnt_full
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    slot_st_e         st_q, st_d;
    logic             pval_q;
    logic [CNT_W-1:0] cnt_q;
    logic             drained, commit;

    assign drained  = (cnt_q == '0);
    assign commit   = (st_q == SLOT_HOLD) && drained;
    assign cnt_full = (cnt_q == CNT_MAX);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_OPEN: st_d = wr ? SLOT_HOLD : SLOT_OPEN;
            SLOT_HOLD: st_d = (wr || !drained) ? SLOT_HOLD : SLOT_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_OPEN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= 1'b1;
            pval_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            if (commit) sec_q  <= pval_q;
            if (wr)     pval_q <= wr_sec;
            cnt_q <= cnt_q + CNT_W'(inc) - CNT_W'(dec);
        end
    end

    // R7: a full counter is never incremented
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_full |-> !inc);
    // R6: the active setting only moves on a drained edge
    a_r6_commit_drained: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_q) |-> $past(drained));
endmodule

// File: rtl/fw_err_resp.sv
module fw_err_resp
    import fw_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] take_slv,
    input  logic             err_ready,
    output logic             err_valid,
    output logic [IDX_W-1:0] err_slv,
    output logic             free
);
    err_st_e st_q, st_d;

    assign err_valid = (st_q == ERR_HOLD);
    assign free      = !err_valid || err_ready;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ERR_IDLE: st_d = take ? ERR_HOLD : ERR_IDLE;
            ERR_HOLD: st_d = (take || !err_ready) ? ERR_HOLD : ERR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ERR_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    err_slv <= '0;
        else if (take) err_slv <= take_slv;
    end

    // R8: a stalled error response keeps its contents
    a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !err_ready) |=> (err_valid && $stable(err_slv)));
endmodule

// File: rtl/fw_cfg_port.sv
module fw_cfg_port
    import fw_pkg::*;
#(
    parameter int NSLV   = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NSLV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic              cfg_write,
    input  logic              cfg_secure,
    input  logic [IDX_W-1:0]  cfg_slv,
    input  logic              cfg_wdata,
    output logic              cfg_rsp_valid,
    input  logic              cfg_rsp_ready,
    output logic [1:0]        cfg_rsp_resp,
    output logic [DATA_W-1:0] cfg_rsp_rdata,
    output logic [NSLV-1:0]   wr_en,
    output logic              wr_sec
);
    cfg_st_e st_q, st_d;
    logic    hs, wr_go;
    resp_e   resp_q;

    assign cfg_rsp_valid = (st_q == CFG_RESP);
    assign cfg_ready     = !cfg_rsp_valid || cfg_rsp_ready;
    assign hs            = cfg_valid && cfg_ready;
    assign wr_go         = hs && cfg_write && cfg_secure;
    assign wr_sec        = cfg_wdata;
    assign cfg_rsp_resp  = resp_q;
    assign cfg_rsp_rdata = '0;

    for (genvar i = 0; i < NSLV; i++) begin : g_wr
        assign wr_en[i] = wr_go && (cfg_slv == IDX_W'(i));
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CFG_IDLE: st_d = hs ? CFG_RESP : CFG_IDLE;
            CFG_RESP: st_d = (hs || !cfg_rsp_ready) ? CFG_RESP : CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  resp_q <= RESP_OKAY;
        else if (hs) resp_q <= cfg_secure ? RESP_OKAY : RESP_DECERR;
    end

    // R9: a waiting response blocks new accesses and holds
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rsp_valid && !cfg_rsp_ready) |=> (cfg_rsp_valid && $stable(cfg_rsp_resp)));
    // R4: a nonsecure access never produces a write strobe
    a_r4_ns_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_secure) |-> (wr_en == '0));
endmodule

// File: rtl/slv_sec_firewall.sv
module slv_sec_firewall
    import fw_pkg::*;
#(
    parameter int NSLV   = 4,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NSLV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_slv,
    input  logic              req_secure,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [IDX_W-1:0]  fwd_slv,
    input  logic              cpl_valid,
    input  logic [IDX_W-1:0]  cpl_slv,
    output logic              err_valid,
    input  logic              err_ready,
    output logic [IDX_W-1:0]  err_slv,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic              cfg_write,
    input  logic              cfg_secure,
    input  logic [IDX_W-1:0]  cfg_slv,
    input  logic              cfg_wdata,
    output logic              cfg_rsp_valid,
    input  logic              cfg_rsp_ready,
    output logic [1:0]        cfg_rsp_resp,
    output logic [DATA_W-1:0] cfg_rsp_rdata
);
    logic [NSLV-1:0] slot_sec, slot_full, inc, dec, wr_en;
    logic            wr_sec, permit, full, err_free, acc_fwd, acc_err;

    assign permit    = !slot_sec[req_slv] || req_secure;
    assign full      = slot_full[req_slv];
    assign fwd_valid = req_valid && permit && !full;
    assign fwd_slv   = req_slv;
    assign req_ready = permit ? (fwd_ready && !full) : err_free;
    assign acc_fwd   = fwd_valid && fwd_ready;
    assign acc_err   = req_valid && !permit && err_free;

    for (genvar i = 0; i < NSLV; i++) begin : g_slot
        assign inc[i] = acc_fwd && (req_slv == IDX_W'(i));
        assign dec[i] = cpl_valid && (cpl_slv == IDX_W'(i));
        fw_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (inc[i]),
            .dec      (dec[i]),
            .wr       (wr_en[i]),
            .wr_sec   (wr_sec),
            .sec_q    (slot_sec[i]),
            .cnt_full (slot_full[i])
        );
    end

    fw_err_resp #(.IDX_W(IDX_W)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (acc_err),
        .take_slv  (req_slv),
        .err_ready (err_ready),
        .err_valid (err_valid),
        .err_slv   (err_slv),
        .free      (err_free)
    );

    fw_cfg_port #(.NSLV(NSLV), .DATA_W(DATA_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_ready     (cfg_ready),
        .cfg_write     (cfg_write),
        .cfg_secure    (cfg_secure),
        .cfg_slv       (cfg_slv),
        .cfg_wdata     (cfg_wdata),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_ready (cfg_rsp_ready),
        .cfg_rsp_resp  (cfg_rsp_resp),
        .cfg_rsp_rdata (cfg_rsp_rdata),
        .wr_en         (wr_en),
        .wr_sec        (wr_sec)
    );

    // R2: nothing nonsecure leaks to a secure slave
    a_r2_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (req_secure || !slot_sec[req_slv]));
    // R2: a refused request shows up as an error one cycle later
    a_r2_err_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !fwd_valid) |=> (err_valid && err_slv == $past(req_slv)));
    // R3: an open, non-full slave passes the request on
    a_r3_open_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !slot_sec[req_slv] && !slot_full[req_slv]) |-> fwd_valid);
endmodule

// File: tb/sim_slv_sec_firewall.sv
module sim_slv_sec_firewall;
    localparam int CLK_PERIOD = 10;
    localparam int NSLV  = 4;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_secure = 0, fwd_ready = 0, cpl_valid = 0, err_ready = 0;
    logic [1:0] req_slv = 0, cpl_slv = 0, cfg_slv = 0;
    logic cfg_valid = 0, cfg_write = 0, cfg_secure = 0, cfg_wdata = 0, cfg_rsp_ready = 0;
    logic req_ready, fwd_valid, err_valid, cfg_ready, cfg_rsp_valid;
    logic [1:0] fwd_slv, err_slv, cfg_rsp_resp;
    logic [31:0] cfg_rsp_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int msec[NSLV], mcnt[NSLV], mpend[NSLV], mpval[NSLV];
    int merr_v, merr_s, mcfg_v, mcfg_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    slv_sec_firewall #(.NSLV(NSLV), .CNT_W(CNT_W), .DATA_W(32)) u0 (.*);

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // compare all outputs against the model, advance one clock, update model
    task automatic cyc();
        int s, permit, full, efree, afwd, aerr, chs, wr;
        #1;
        s      = req_slv;
        permit = (msec[s] == 0) || req_secure;
        full   = (mcnt[s] == CMAX);
        efree  = (merr_v == 0) || err_ready;
        check("R2 R3 R7 fwd_valid", fwd_valid, req_valid && permit && !full);
        check("R2 R3 R7 R8 req_ready", req_ready, permit ? (fwd_ready && !full) : efree);
        if (fwd_valid) check("R3 fwd_slv", fwd_slv, s);
        check("R2 R8 err_valid", err_valid, merr_v);
        if (merr_v) check("R2 R8 err_slv", err_slv, merr_s);
        check("R9 cfg_ready", cfg_ready, (mcfg_v == 0) || cfg_rsp_ready);
        check("R4 R9 cfg_rsp_valid", cfg_rsp_valid, mcfg_v);
        if (mcfg_v) begin
            check("R4 cfg_rsp_resp", cfg_rsp_resp, mcfg_r);
            check("R5 cfg_rsp_rdata", int'(cfg_rsp_rdata), 0);
        end
        afwd = req_valid && permit && !full && fwd_ready;
        aerr = req_valid && !permit && efree;
        chs  = cfg_valid && ((mcfg_v == 0) || cfg_rsp_ready);
        wr   = chs && cfg_write && cfg_secure;
        @(posedge clk);
        for (int i = 0; i < NSLV; i++) begin
            int commit;
            commit = mpend[i] && (mcnt[i] == 0);
            if (commit) msec[i] = mpval[i];
            if (afwd && s == i) mcnt[i]++;
            if (cpl_valid && cpl_slv == i) mcnt[i]--;
            if (wr && cfg_slv == i) begin mpend[i] = 1; mpval[i] = cfg_wdata; end
            else if (commit) mpend[i] = 0;
        end
        if (aerr) begin merr_v = 1; merr_s = s; end
        else if (err_ready) merr_v = 0;
        if (chs) begin mcfg_v = 1; mcfg_r = cfg_secure ? 0 : 3; end
        else if (cfg_rsp_ready) mcfg_v = 0;
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 0; cpl_valid = 0; cfg_valid = 0;
        err_ready = 1; cfg_rsp_ready = 1; fwd_ready = 1;
    endtask

    task automatic cfg_acc(int slv, int sec, int wrt, int val);
        idle();
        cfg_valid = 1; cfg_slv = 2'(slv); cfg_secure = sec[0]; cfg_write = wrt[0]; cfg_wdata = val[0];
        cyc();
        cfg_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NSLV; i++) begin msec[i] = 1; mcnt[i] = 0; mpend[i] = 0; mpval[i] = 1; end
        merr_v = 0; merr_s = 0; mcfg_v = 0; mcfg_r = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        #1;
        check("R1 err_valid after reset", err_valid, 0);
        check("R1 cfg_rsp_valid after reset", cfg_rsp_valid, 0);
        // R1: every slave refuses nonsecure traffic out of reset
        for (int s = 0; s < NSLV; s++) begin
            req_valid = 1; req_slv = 2'(s); req_secure = 0;
            #1 check("R1 slave secure at reset", fwd_valid, 0);
            cyc();
        end
        idle();
        cyc();
        // R3: secure request passes
        req_valid = 1; req_slv = 0; req_secure = 1;
        #1 check("R3 secure forward", fwd_valid, 1);
        cyc();
        idle(); cpl_valid = 1; cpl_slv = 0; cyc(); idle();
        // R4: nonsecure write rejected and ineffective
        cfg_acc(1, 0, 1, 0);
        #1 check("R4 nonsecure write DECERR", cfg_rsp_resp, 3);
        cyc(); cyc();
        req_valid = 1; req_slv = 1; req_secure = 0;
        #1 check("R4 setting unchanged", fwd_valid, 0);
        cyc(); idle();
        // R4 then R3: secure write opens slave 1
        cfg_acc(1, 1, 1, 0);
        #1 check("R4 secure write OKAY", cfg_rsp_resp, 0);
        cyc();
        req_valid = 1; req_slv = 1; req_secure = 0;
        #1 check("R3 nonsecure to open slave", fwd_valid, 1);
        cyc(); idle(); cpl_valid = 1; cpl_slv = 1; cyc(); idle();
        // R5: read gives zero
        cfg_acc(1, 1, 0, 1);
        #1 check("R5 read data zero", int'(cfg_rsp_rdata), 0);
        check("R5 read OKAY", cfg_rsp_resp, 0);
        cyc();
        // R6: deferral while slave 2 has three in flight
        for (int k = 0; k < 3; k++) begin
            req_valid = 1; req_slv = 2; req_secure = 1; cyc();
        end
        cfg_acc(2, 1, 1, 0);
        for (int k = 0; k < 3; k++) begin
            idle(); req_valid = 1; req_slv = 2; req_secure = 0;
            #1 check("R6 change held while busy", fwd_valid, 0);
            cpl_valid = 1; cpl_slv = 2;
            cyc();
        end
        idle(); req_valid = 1; req_slv = 2; req_secure = 0;
        #1 check("R6 still old on drain cycle", fwd_valid, 0);
        cyc();
        #1 check("R6 change applied after drain", fwd_valid, 1);
        cyc(); idle(); cpl_valid = 1; cpl_slv = 2; cyc(); idle();
        // R7: fill slave 3
        for (int k = 0; k < CMAX; k++) begin
            req_valid = 1; req_slv = 3; req_secure = 1; cyc();
        end
        #1 check("R7 full stalls fwd_valid", fwd_valid, 0);
        check("R7 full stalls req_ready", req_ready, 0);
        cyc();
        for (int k = 0; k < CMAX; k++) begin
            idle(); cpl_valid = 1; cpl_slv = 3; cyc();
        end
        idle();
        // R8: error backpressure
        err_ready = 0; req_valid = 1; req_slv = 0; req_secure = 0;
        cyc();
        #1 check("R8 second refusal stalls", req_ready, 0);
        cyc(); cyc();
        check("R8 err held", err_valid, 1);
        err_ready = 1; cyc(); idle(); cyc();
        // R9: configuration backpressure
        cfg_rsp_ready = 0; cfg_valid = 1; cfg_write = 0; cfg_secure = 1; cfg_slv = 0;
        cyc();
        #1 check("R9 cfg_ready low while waiting", cfg_ready, 0);
        cyc(); cyc(); idle(); cyc();
        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            int cs;
            req_valid  = ($urandom_range(0, 3) != 0);
            req_slv    = 2'($urandom_range(0, 3));
            req_secure = $urandom_range(0, 1) == 1;
            fwd_ready  = ($urandom_range(0, 3) != 0);
            err_ready  = ($urandom_range(0, 2) != 0);
            cs         = $urandom_range(0, 3);
            cpl_slv    = 2'(cs);
            cpl_valid  = (mcnt[cs] > 0) && ($urandom_range(0, 1) == 1);
            cfg_valid  = ($urandom_range(0, 7) == 0);
            cfg_write  = ($urandom_range(0, 3) != 0);
            cfg_secure = ($urandom_range(0, 3) != 0);
            cfg_slv    = 2'($urandom_range(0, 3));
            cfg_wdata  = $urandom_range(0, 1) == 1;
            cfg_rsp_ready = ($urandom_range(0, 2) != 0);
            cyc();
        end
        idle();
        cyc();
        finish_run();
    end
endmodule